// File: doc/BRIEF.md
# Double-Buffered Frame Base Address Registers

This block holds the frame-buffer start addresses for a display controller. The controller can drive a single panel, or a dual panel split into an upper half and a lower half. Software writes a staging address for each half over a simple register bus. A single-cycle vertical-sync pulse moves both staged addresses into a pair of live registers, and those live registers feed the display DMA. The lower-half address matters only when the controller drives a dual panel, but it is staged and moved on every pulse in either case.

Each transfer sets an update flag that tells software it may rewrite both staging registers for the next frame. The flag also drives an interrupt, which software can mask. Software clears the flag by writing one to it. With this scheme software can rewrite a staging address at any point in a frame, and the DMA sees the new address only from the next vertical sync. That is what makes double-buffered video possible.

The update flag is a two-state machine. In `ST_CLEAR` no transfer is pending acknowledgement. In `ST_PENDING` a transfer has happened and software has not yet cleared it. The machine has three transitions:
- `T_SYNC`: a vsync pulse in either state leads to `ST_PENDING`.
- `T_ACK`: a write of one to the flag with no vsync in the same cycle leads from `ST_PENDING` to `ST_CLEAR`.
- `T_STAY`: in every other case the state holds.

Top module: `fbb_frame_base`

## Requirements
- R1: After reset, both staging registers, both live outputs, the flag and the mask read or drive 0, and `irq` is 0.
- R2: The staging registers sit at offsets 0x10 (upper) and 0x14 (lower). Bits 31:2 can be written and read back. Bits 1:0 always read 0, and writes to them are ignored.
- R3: A staging write does not change either live output until the next vsync pulse.
- R4: A vsync pulse copies both staging registers into the live outputs. The new values are visible from the clock edge that samples the pulse.
- R5: A vsync pulse sets the flag, which is bit 0 of the status register at offset 0x18.
- R6: Writing 1 to status bit 0 clears the flag. Writing 0 leaves the flag unchanged.
- R7: A clear write in the same cycle as a vsync pulse leaves the flag set.
- R8: `irq` equals the flag ANDed with the mask bit. The mask bit is bit 0 of the register at offset 0x1C, and it reads back as written.
- R9: Any offset other than 0x10, 0x14, 0x18 and 0x1C reads 0, and writes to it change no register. With `bus_sel` low, `bus_rdata` is 0.
- R10: A staging write in the same cycle as a vsync pulse does two things. The live output takes the value held before the write, and the written value is copied on the following pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; vsync is synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| vsync | input | 1 | Single-cycle vertical-sync pulse |
| cur_upper_base | output | 32 | Live upper-half base address for the DMA |
| cur_lower_base | output | 32 | Live lower-half base address for the DMA |
| irq | output | 1 | Base-update interrupt |

## Verification
Each fault in this block shows at the ports within one cycle of the event that exposes it:
- A live register that loads outside a vsync pulse shows on its output at the edge after the staging write. The bench therefore reads the live outputs immediately after every write in a walking-one sweep.
- A flag machine that enters or leaves `ST_PENDING` at the wrong time shows through two paths: the status readback and `irq`, once for each combination of mask and flag.
- Decode faults show as nonzero reads from unmapped offsets, or as corrupted staging values after writes to those offsets.
- The same-cycle races are the cases most likely to hide wrong state. These are a vsync with a write, and a vsync with a clear. The bench drives each race and checks it on the next cycle.

// File: rtl/fbb_pkg.sv
package fbb_pkg;

    localparam int unsigned NPANEL   = 2;
    localparam int unsigned PANEL_UP = 0;
    localparam int unsigned PANEL_LO = 1;

    typedef enum logic [0:0] {
        ST_CLEAR   = 1'b0,
        ST_PENDING = 1'b1
    } upd_state_e;

endpackage

// File: rtl/fbb_regfile.sv
module fbb_regfile
    import fbb_pkg::*;
#(
    parameter int unsigned     AW         = 8,
    parameter int unsigned     DW         = 32,
    parameter int unsigned     ALIGN      = 2,
    parameter logic [AW-1:0]   OFS_UPPER  = 8'h10,
    parameter logic [AW-1:0]   OFS_LOWER  = 8'h14,
    parameter logic [AW-1:0]   OFS_STATUS = 8'h18,
    parameter logic [AW-1:0]   OFS_MASK   = 8'h1C
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [AW-1:0]                bus_addr,
    input  logic [DW-1:0]                bus_wdata,
    input  logic                         flag,
    output logic [NPANEL-1:0][DW-1:0]    prog_base,
    output logic                         irq_en,
    output logic                         clr_req,
    output logic [DW-1:0]                bus_rdata
);

    localparam int unsigned HIW = DW - ALIGN;

    logic wr_en;
    logic irq_en_q;

    assign wr_en = bus_sel & bus_wr;

    // one staging register per panel half; only the aligned bits are stored
    for (genvar g = 0; g < NPANEL; g++) begin : g_stage
        localparam logic [AW-1:0] OFS = (g == PANEL_UP) ? OFS_UPPER : OFS_LOWER;
        logic [HIW-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (wr_en && (bus_addr == OFS)) begin
                hi_q <= bus_wdata[DW-1:ALIGN];
            end
        end

        assign prog_base[g] = {hi_q, {ALIGN{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
        end else if (wr_en && (bus_addr == OFS_MASK)) begin
            irq_en_q <= bus_wdata[0];
        end
    end

    assign irq_en  = irq_en_q;
    assign clr_req = wr_en && (bus_addr == OFS_STATUS) && bus_wdata[0];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == OFS_UPPER) begin
                bus_rdata = prog_base[PANEL_UP];
            end else if (bus_addr == OFS_LOWER) begin
                bus_rdata = prog_base[PANEL_LO];
            end else if (bus_addr == OFS_STATUS) begin
                bus_rdata = {{(DW-1){1'b0}}, flag};
            end else if (bus_addr == OFS_MASK) begin
                bus_rdata = {{(DW-1){1'b0}}, irq_en_q};
            end
        end
    end

    // R2: a base readback never shows the reserved low bits
    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && ((bus_addr == OFS_UPPER) || (bus_addr == OFS_LOWER)))
            |-> (bus_rdata[ALIGN-1:0] == '0));

    // R8: a mask write lands on the next cycle
    assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bus_addr == OFS_MASK)) |=> (irq_en == $past(bus_wdata[0])));

endmodule

// File: rtl/fbb_shadow.sv
module fbb_shadow
    import fbb_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vsync,
    input  logic [NPANEL-1:0][DW-1:0]  prog_base,
    output logic [NPANEL-1:0][DW-1:0]  cur_base
);

    for (genvar g = 0; g < NPANEL; g++) begin : g_live
        logic [DW-1:0] cur_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q <= '0;
            end else if (vsync) begin
                cur_q <= prog_base[g];
            end
        end

        assign cur_base[g] = cur_q;
    end

    // R3: outside a sync pulse the live addresses do not move
    assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(cur_base));

    // R4 / R10: a sync pulse loads the staging value seen at that edge
    assert_live_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (cur_base == $past(prog_base)));

endmodule

// File: rtl/fbb_status_fsm.sv
module fbb_status_fsm
    import fbb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    upd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (vsync) state_d = ST_PENDING;          // T_SYNC
            end
            ST_PENDING: begin
                if (clr_req && !vsync) state_d = ST_CLEAR; // T_ACK
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag = (state_q == ST_PENDING);
        irq  = flag & irq_en;
    end

    // R5 / R7: a sync pulse always leaves the flag set, clear or not
    assert_sync_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> flag);

    // R6: an acknowledge without a sync pulse clears the flag
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr_req && !vsync) |=> !flag);

    // R6: the flag never rises without a sync pulse
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !vsync) |=> !flag);

endmodule

// File: rtl/fbb_frame_base.sv
module fbb_frame_base
    import fbb_pkg::*;
#(
    parameter int unsigned     AW         = 8,
    parameter int unsigned     DW         = 32,
    parameter int unsigned     ALIGN      = 2,
    parameter logic [AW-1:0]   OFS_UPPER  = 8'h10,
    parameter logic [AW-1:0]   OFS_LOWER  = 8'h14,
    parameter logic [AW-1:0]   OFS_STATUS = 8'h18,
    parameter logic [AW-1:0]   OFS_MASK   = 8'h1C
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic           vsync,
    output logic [DW-1:0]  cur_upper_base,
    output logic [DW-1:0]  cur_lower_base,
    output logic           irq
);

    logic [NPANEL-1:0][DW-1:0] prog_base;
    logic [NPANEL-1:0][DW-1:0] cur_base;
    logic                      irq_en;
    logic                      clr_req;
    logic                      flag;

    fbb_regfile #(
        .AW(AW), .DW(DW), .ALIGN(ALIGN),
        .OFS_UPPER(OFS_UPPER), .OFS_LOWER(OFS_LOWER),
        .OFS_STATUS(OFS_STATUS), .OFS_MASK(OFS_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (flag),
        .prog_base (prog_base),
        .irq_en    (irq_en),
        .clr_req   (clr_req),
        .bus_rdata (bus_rdata)
    );

    fbb_shadow #(.DW(DW)) u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .prog_base (prog_base),
        .cur_base  (cur_base)
    );

    fbb_status_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync   (vsync),
        .clr_req (clr_req),
        .irq_en  (irq_en),
        .flag    (flag),
        .irq     (irq)
    );

    assign cur_upper_base = cur_base[PANEL_UP];
    assign cur_lower_base = cur_base[PANEL_LO];

    // R8: the interrupt is only raised while enabled and pending
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && flag));

endmodule

// File: tb/sim_fbb_frame_base.sv
`timescale 1ns/1ps
module sim_fbb_frame_base;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        vsync = 1'b0;
    logic [31:0] cur_upper_base;
    logic [31:0] cur_lower_base;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fbb_frame_base u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vsync(vsync), .cur_upper_base(cur_upper_base),
        .cur_lower_base(cur_lower_base), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic wr_with_sync(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; vsync = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; vsync = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] exp_up, exp_lo, live_up, live_lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h10, r); check("R1 upper staging", r, 32'h0);
        rd(8'h14, r); check("R1 lower staging", r, 32'h0);
        rd(8'h18, r); check("R1 flag", r, 32'h0);
        rd(8'h1C, r); check("R1 mask", r, 32'h0);
        check("R1 live upper", cur_upper_base, 32'h0);
        check("R1 live lower", cur_lower_base, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2/R3/R4/R5: walking-one sweep over every bit position
        live_up = 32'h0; live_lo = 32'h0;
        for (int b = 0; b < 32; b++) begin
            exp_up = (32'h1 << b) & 32'hFFFF_FFFC;
            exp_lo = ~(32'h1 << b) & 32'hFFFF_FFFC;
            wr(8'h10, 32'h1 << b);
            wr(8'h14, ~(32'h1 << b));
            rd(8'h10, r); check("R2 upper readback", r, exp_up);
            rd(8'h14, r); check("R2 lower readback", r, exp_lo);
            check("R3 live upper held", cur_upper_base, live_up);
            check("R3 live lower held", cur_lower_base, live_lo);
            sync_pulse();
            check("R4 live upper copied", cur_upper_base, exp_up);
            check("R4 live lower copied", cur_lower_base, exp_lo);
            rd(8'h18, r); check("R5 flag set by sync", r, 32'h1);
            wr(8'h18, 32'h1);
            live_up = exp_up; live_lo = exp_lo;
        end

        // R6: write 0 keeps, write 1 clears
        sync_pulse();
        wr(8'h18, 32'hFFFF_FFFE);
        rd(8'h18, r); check("R6 zero write keeps flag", r, 32'h1);
        wr(8'h18, 32'h1);
        rd(8'h18, r); check("R6 one write clears flag", r, 32'h0);

        // R7: clear and sync in same cycle, from both states
        wr_with_sync(8'h18, 32'h1);
        rd(8'h18, r); check("R7 clear+sync from clear", r, 32'h1);
        wr_with_sync(8'h18, 32'h1);
        rd(8'h18, r); check("R7 clear+sync from pending", r, 32'h1);

        // R8: every mask/flag combination
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 2; f++) begin
                wr(8'h1C, 32'(m) | 32'hFFFF_FFFE);
                if (f == 1) sync_pulse(); else wr(8'h18, 32'h1);
                rd(8'h1C, r); check("R8 mask readback", r, 32'(m));
                rd(8'h18, r); check("R8 flag readback", r, 32'(f));
                check("R8 irq", {31'b0, irq}, 32'(m & f));
            end
        end
        wr(8'h1C, 32'h0);
        check("R8 irq masked off", {31'b0, irq}, 32'h0);

        // R10: staging write concurrent with sync
        wr(8'h10, 32'hAAAA_0000);
        wr(8'h14, 32'h5555_0004);
        sync_pulse();
        wr_with_sync(8'h10, 32'h1234_5678);
        check("R10 live upper takes old value", cur_upper_base, 32'hAAAA_0000);
        check("R10 live lower unaffected", cur_lower_base, 32'h5555_0004);
        rd(8'h10, r); check("R10 staging keeps new value", r, 32'h1234_5678);
        sync_pulse();
        check("R10 new value on next sync", cur_upper_base, 32'h1234_5678);

        // R9: unmapped offsets
        wr(8'h18, 32'h1);
        for (int a = 0; a < 256; a += 4) begin
            if (a != 8'h10 && a != 8'h14 && a != 8'h18 && a != 8'h1C) begin
                wr(8'(a), 32'hFFFF_FFFF);
                rd(8'(a), r); check("R9 unmapped reads 0", r, 32'h0);
            end
        end
        rd(8'h10, r); check("R9 upper untouched", r, 32'h1234_5678);
        rd(8'h14, r); check("R9 lower untouched", r, 32'h5555_0004);
        rd(8'h18, r); check("R9 flag untouched", r, 32'h0);
        rd(8'h1C, r); check("R9 mask untouched", r, 32'h0);
        @(negedge clk);
        bus_addr = 8'h10; bus_sel = 1'b0;
        #1 check("R9 rdata idle", bus_rdata, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule